// File: doc/BRIEF.md
# Data EEPROM access controller

This block sits on the I/O bus of a small 8-bit processor. Through it the processor reaches a 64-byte non-volatile data store, which is modelled inside the block as a behavioural array. Software sees three byte-wide registers: an address register, a data register and a control register. It chooses a location, and then sets one bit in the control register to start either a read or a write.

A read copies the addressed byte into the data register. A write copies the data register into the addressed byte. The write is self-timed and runs for `WRITE_CYCLES` clock cycles. The write-enable bit reads back as set for that whole interval, so software can poll it to learn when the next write may begin. Every accepted access asserts a stall output toward the CPU for exactly two cycles. While a write is running, the block refuses new accesses and freezes its address and data registers.

Top module: `nvm_access_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the address, data and control registers all read as zero and `cpu_stall` is low.
- R2: The address register sits at I/O offset 0x1E. Bits 5..0 can be written and read back. Bits 7..6 always read as zero.
- R3: The data register sits at I/O offset 0x1D and holds all 8 bits as written.
- R4: The control register sits at I/O offset 0x1C. Bit 1 is write-enable/busy and bit 0 is read-enable. Bits 7..2 read as zero. An offset that maps to no register reads as zero.
- R5: Writing the control register with bit 1 set starts a write of the data register to the addressed byte. Bit 1 then reads as 1 for exactly `WRITE_CYCLES` cycles, starting in the cycle after the strobe, and clears itself afterwards.
- R6: Writing the control register with bit 0 set and bit 1 clear loads the data register from the addressed byte. This completes before the stall ends. Bit 0 reads as 1 for one cycle and then clears itself.
- R7: Each accepted read or write access drives `cpu_stall` high for exactly two cycles, starting in the cycle after the strobe.
- R8: While a write is in progress, bus writes to any of the three registers are ignored. No access starts, no stall occurs, and the address and data registers keep their values.
- R9: If bits 1 and 0 are both set in one control write, only the write is performed. The data register keeps its value.
- R10: A byte written by a completed write is returned by every later read of that address, and locations that were not addressed keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 6 | I/O register offset |
| io_wdata | input | 8 | Bus write data |
| io_we | input | 1 | Bus write strobe |
| io_re | input | 1 | Bus read strobe |
| io_rdata | output | 8 | Bus read data, combinational, zero when `io_re` is low |
| cpu_stall | output | 1 | Holds the CPU while an access completes |

## Verification
The assertions check on every cycle the properties that need no memory contents:
- a stall pulse always lasts two cycles;
- the busy bit never outlives the write interval and always covers it in full;
- the read-enable bit self-clears;
- no stall starts while a write is running;
- the address and data registers stay frozen during a write.

Only the bench scenarios can show the data path: random bytes written to random locations and read back, reserved bits masked on readback, and the priority when both enable bits are set. The same holds for the ignored writes during the busy window.

// File: rtl/nvm_pkg.sv
// Package: shared constants for the data EEPROM access controller.
// Assumes an 8-bit I/O data bus and 6-bit I/O offsets.
package nvm_pkg;
    localparam int OFF_ADDR = 'h1E;   // address register offset
    localparam int OFF_DATA = 'h1D;   // data register offset
    localparam int OFF_CTRL = 'h1C;   // control register offset
    localparam int BIT_WEN  = 1;      // write enable / busy bit
    localparam int BIT_REN  = 0;      // read enable strobe bit
endpackage

// File: rtl/nvm_store.sv
// Module: behavioural non-volatile byte array.
// Writes land on the commit pulse; reads are combinational.
// Assumes the commit pulse is issued only by the sequencer.
module nvm_store #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              commit_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Store the byte when the self-timed write finishes.
    always_ff @(posedge clk) begin
        if (commit_i) cells[addr_i] <= wdata_i;
    end

    // Present the addressed byte.
    always_comb rdata_o = cells[addr_i];
endmodule

// File: rtl/nvm_sequencer.sv
// Module: access sequencer. It accepts control-register writes,
// runs the self-timed write, drives the read-load strobe and the CPU stall.
// Assumes the CPU issues no access while it is stalled.
module nvm_sequencer #(
    parameter int WRITE_CYCLES = 10000,
    parameter int STALL_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr_i,
    input  logic wen_i,
    input  logic ren_i,
    output logic busy_o,
    output logic ren_o,
    output logic commit_o,
    output logic stall_o,
    output logic idle_o
);
    localparam int TIMER_W = $clog2(WRITE_CYCLES + 1);
    localparam int STALL_W = $clog2(STALL_CYCLES + 1);

    logic [TIMER_W-1:0] timer_q;
    logic [STALL_W-1:0] stall_q;
    logic               busy_q, ren_q;
    logic               accept, start_wr, start_rd;

    always_comb begin
        idle_o   = !busy_q && (stall_q == '0);
        accept   = ctrl_wr_i && idle_o;
        start_wr = accept && wen_i;
        start_rd = accept && !wen_i && ren_i;
        commit_o = busy_q && (timer_q == TIMER_W'(1));
        busy_o   = busy_q;
        ren_o    = ren_q;
        stall_o  = (stall_q != '0);
    end

    // Count down the self-timed write interval and hold the busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            timer_q <= '0;
        end else if (start_wr) begin
            busy_q  <= 1'b1;
            timer_q <= TIMER_W'(WRITE_CYCLES);
        end else if (busy_q) begin
            timer_q <= timer_q - TIMER_W'(1);
            if (commit_o) busy_q <= 1'b0;
        end
    end

    // Raise the read strobe for one cycle; it self-clears after the load.
    always_ff @(posedge clk) begin
        if (!rst_n) ren_q <= 1'b0;
        else        ren_q <= start_rd;
    end

    // Hold the CPU for a fixed number of cycles after each access.
    always_ff @(posedge clk) begin
        if (!rst_n)                     stall_q <= '0;
        else if (start_wr || start_rd)  stall_q <= STALL_W'(STALL_CYCLES);
        else if (stall_q != '0)         stall_q <= stall_q - STALL_W'(1);
    end

    // Checker state: number of cycles the busy flag has been high.
    logic [TIMER_W:0] chk_busy_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)      chk_busy_cnt <= '0;
        else if (busy_q) chk_busy_cnt <= chk_busy_cnt + 1'b1;
        else             chk_busy_cnt <= '0;
    end

    assert_busy_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> chk_busy_cnt == (TIMER_W+1)'(WRITE_CYCLES));
    assert_busy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> chk_busy_cnt < (TIMER_W+1)'(WRITE_CYCLES));
    assert_ren_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ren_q |=> !ren_q);
    assert_stall_two_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_o) |=> stall_o ##1 !stall_o);
    assert_no_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_o) |-> !$past(busy_q));
endmodule

// File: rtl/nvm_regfile.sv
// Module: I/O register file holding the address and data registers,
// plus the read multiplexer with reserved-bit masking.
// Assumes the sequencer's idle flag gates every register update.
module nvm_regfile
    import nvm_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int IO_AW  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_we,
    input  logic              io_re,
    input  logic              idle_i,
    input  logic              busy_i,
    input  logic              ren_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              ctrl_wr_o,
    output logic [DATA_W-1:0] io_rdata
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              hit_addr, hit_data, hit_ctrl;

    always_comb begin
        hit_addr  = (io_addr == IO_AW'(OFF_ADDR));
        hit_data  = (io_addr == IO_AW'(OFF_DATA));
        hit_ctrl  = (io_addr == IO_AW'(OFF_CTRL));
        ctrl_wr_o = io_we && hit_ctrl;
        addr_o    = addr_q;
        data_o    = data_q;
    end

    // Update the address register from the bus when no access is running.
    always_ff @(posedge clk) begin
        if (!rst_n)                          addr_q <= '0;
        else if (io_we && hit_addr && idle_i) addr_q <= io_wdata[ADDR_W-1:0];
    end

    // Update the data register from the bus, or from the store on a read.
    always_ff @(posedge clk) begin
        if (!rst_n)                           data_q <= '0;
        else if (ren_i)                       data_q <= mem_rdata_i;
        else if (io_we && hit_data && idle_i) data_q <= io_wdata;
    end

    // Return the selected register; reserved and unmapped bits read as zero.
    always_comb begin
        io_rdata = '0;
        if (io_re) begin
            if (hit_addr)      io_rdata = DATA_W'(addr_q);
            else if (hit_data) io_rdata = data_q;
            else if (hit_ctrl) begin
                io_rdata[BIT_WEN] = busy_i;
                io_rdata[BIT_REN] = ren_i;
            end
        end
    end

    assert_hold_regs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy_i) && busy_i) |-> ($stable(addr_q) && $stable(data_q)));
    assert_addr_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_re && hit_addr) |-> io_rdata[DATA_W-1:ADDR_W] == '0);
endmodule

// File: rtl/nvm_access_ctrl.sv
// Module: top of the data EEPROM access controller. It joins the register
// file, the sequencer and the behavioural store.
// Assumes a single-master I/O bus and a CPU that honours cpu_stall.
module nvm_access_ctrl
    import nvm_pkg::*;
#(
    parameter int ADDR_W       = 6,
    parameter int DATA_W       = 8,
    parameter int IO_AW        = 6,
    parameter int WRITE_CYCLES = 10000,
    parameter int STALL_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_we,
    input  logic              io_re,
    output logic [DATA_W-1:0] io_rdata,
    output logic              cpu_stall
);
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_data, mem_rdata;
    logic              ctrl_wr, busy, ren, commit, idle;

    nvm_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IO_AW(IO_AW)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_we(io_we), .io_re(io_re),
        .idle_i(idle), .busy_i(busy), .ren_i(ren), .mem_rdata_i(mem_rdata),
        .addr_o(cur_addr), .data_o(cur_data), .ctrl_wr_o(ctrl_wr),
        .io_rdata(io_rdata)
    );

    nvm_sequencer #(.WRITE_CYCLES(WRITE_CYCLES), .STALL_CYCLES(STALL_CYCLES)) seq_i (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr_i(ctrl_wr), .wen_i(io_wdata[BIT_WEN]), .ren_i(io_wdata[BIT_REN]),
        .busy_o(busy), .ren_o(ren), .commit_o(commit), .stall_o(cpu_stall),
        .idle_o(idle)
    );

    nvm_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) store_i (
        .clk(clk), .commit_i(commit), .addr_i(cur_addr),
        .wdata_i(cur_data), .rdata_o(mem_rdata)
    );
endmodule

// File: tb/nvm_access_ctrl_tb_top.sv
module nvm_access_ctrl_tb_top;
    localparam int WC = 30;
    localparam logic [5:0] A_ADDR = 6'h1E, A_DATA = 6'h1D, A_CTRL = 6'h1C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] io_addr = '0;
    logic [7:0] io_wdata = '0;
    logic       io_we = 1'b0, io_re = 1'b0;
    logic [7:0] io_rdata;
    logic       cpu_stall;

    int total = 0, bad = 0;
    logic [7:0] shadow [64];
    bit         valid [64];

    always #2 clk = ~clk;   // 250 MHz

    nvm_access_ctrl #(.WRITE_CYCLES(WC)) dut_i (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_we(io_we), .io_re(io_re), .io_rdata(io_rdata), .cpu_stall(cpu_stall)
    );

    function automatic logic [7:0] exp_addr_rb(logic [7:0] v);
        return v & 8'h3F;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [5:0] a, logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_we = 1'b1;
        @(negedge clk);
        io_we = 1'b0;
    endtask

    task automatic bus_rd(logic [5:0] a, output logic [7:0] d);
        io_addr = a; io_re = 1'b1;
        #1 d = io_rdata;
        io_re = 1'b0;
    endtask

    // Full write with stall and busy-length checks (R5, R7).
    task automatic do_write(logic [5:0] a, logic [7:0] d, bit check_len);
        logic [7:0] v;
        int n;
        bus_wr(A_ADDR, {2'b00, a});
        bus_wr(A_DATA, d);
        bus_wr(A_CTRL, 8'h02);
        n = 0;
        for (int k = 0; k < WC + 10; k++) begin
            if (k <= 2) check("R7 stall", {7'd0, cpu_stall}, {7'd0, k < 2});
            bus_rd(A_CTRL, v);
            if (!v[1]) break;
            n++;
            @(negedge clk);
        end
        if (check_len) check("R5 busy length", 8'(n), 8'(WC));
        shadow[a] = d; valid[a] = 1'b1;
    endtask

    // Read access with stall and self-clear checks (R6, R7).
    task automatic do_read(logic [5:0] a, output logic [7:0] d);
        logic [7:0] v;
        bus_wr(A_ADDR, {2'b00, a});
        bus_wr(A_CTRL, 8'h01);
        check("R7 stall c1", {7'd0, cpu_stall}, 8'd1);
        bus_rd(A_CTRL, v);
        check("R6 ren set", v, 8'h01);
        @(negedge clk);
        check("R7 stall c2", {7'd0, cpu_stall}, 8'd1);
        @(negedge clk);
        check("R7 stall end", {7'd0, cpu_stall}, 8'd0);
        bus_rd(A_CTRL, v);
        check("R6 ren clear", v, 8'h00);
        bus_rd(A_DATA, d);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        logic [5:0] a;
        logic [7:0] d;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_rd(A_ADDR, v); check("R1 addr reset", v, 8'h00);
        bus_rd(A_DATA, v); check("R1 data reset", v, 8'h00);
        bus_rd(A_CTRL, v); check("R1 ctrl reset", v, 8'h00);
        check("R1 stall reset", {7'd0, cpu_stall}, 8'd0);

        // R2 reserved address bits, R3 data register, R4 unmapped/reserved
        bus_wr(A_ADDR, 8'hFF);
        bus_rd(A_ADDR, v); check("R2 addr mask", v, exp_addr_rb(8'hFF));
        bus_wr(A_DATA, 8'hA5);
        bus_rd(A_DATA, v); check("R3 data rw", v, 8'hA5);
        bus_rd(6'h00, v);  check("R4 unmapped", v, 8'h00);
        bus_wr(A_CTRL, 8'hFC);
        bus_rd(A_CTRL, v); check("R4 ctrl reserved", v, 8'h00);
        check("R4 no stall", {7'd0, cpu_stall}, 8'd0);

        // Directed boundary addresses
        do_write(6'd0, 8'h3C, 1'b1);
        do_write(6'd63, 8'hC3, 1'b1);

        // Random writes (R5)
        for (int i = 0; i < 6; i++) begin
            a = 6'($urandom_range(1, 62));
            d = 8'($urandom);
            do_write(a, d, i < 2);
        end

        // R8: ignored writes while busy
        bus_wr(A_ADDR, 8'd5);
        bus_wr(A_DATA, 8'h11);
        bus_wr(A_CTRL, 8'h02);
        @(negedge clk); @(negedge clk);
        bus_wr(A_ADDR, 8'd9);
        bus_wr(A_DATA, 8'h99);
        bus_wr(A_CTRL, 8'h01);
        check("R8 no stall busy", {7'd0, cpu_stall}, 8'd0);
        bus_rd(A_ADDR, v); check("R8 addr held", v, 8'd5);
        bus_rd(A_DATA, v); check("R8 data held", v, 8'h11);
        repeat (WC + 2) @(negedge clk);
        bus_rd(A_CTRL, v); check("R5 busy done", v, 8'h00);
        shadow[5] = 8'h11; valid[5] = 1'b1;

        // R9: both enables set -> write only, data register unchanged
        bus_wr(A_ADDR, 8'd7);
        bus_wr(A_DATA, 8'h5A);
        bus_wr(A_CTRL, 8'h03);
        bus_rd(A_CTRL, v); check("R9 write only", v, 8'h02);
        repeat (WC + 2) @(negedge clk);
        bus_rd(A_DATA, v); check("R9 data kept", v, 8'h5A);
        shadow[7] = 8'h5A; valid[7] = 1'b1;

        // R10 / R6: read back every written location
        for (int k = 0; k < 64; k++) begin
            if (valid[k]) begin
                do_read(6'(k), v);
                check("R10 readback", v, shadow[k]);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule